// File: doc/BRIEF.md
# Audio Frame Sequencer with Frame Interrupt

This block divides the CPU clock into the uneven, cycle-exact step schedule that drives the slow units of an audio processing unit. It uses the 50 Hz-region step spacing. On each step it raises a one-cycle quarter-frame strobe, which clocks the envelope and linear-counter logic. On some steps it also raises a one-cycle half-frame strobe, which clocks the length-counter and sweep logic. In the four-step sequence the last step also sets a frame interrupt flag.

Software controls the block through one control write and one status read. The control byte carries two fields. Bit 7 picks the sequence: 0 selects four steps, 1 selects five steps. Bit 6 inhibits the interrupt. Every control write restarts the sequence from its first interval. A five-step write also clocks both strobes at once. The status read strobe clears the flag unless the set window is active. The interrupt line is a direct copy of the flag.

Timing convention: call the cycle in which `ctrl_wr` is high cycle 0. "Cycle n" is then the n-th cycle after it, and the strobes and flag are registered outputs seen in that cycle. Reset behaves like a write of 0x00 that also clears the flag, with the last reset cycle taken as cycle 0.

Top module: `afs_frame_seq`

## Requirements
- R1: While in reset and in the cycle after it, both strobes and the flag are 0. After reset the four-step sequence runs, and its first step falls 8315 cycles after the last reset cycle.
- R2: After a write with bit 7 = 0, the first quarter-frame strobe falls in cycle 8315 and lasts exactly one cycle. Cycles 8314 and 8316 show no strobe.
- R3: In four-step mode the steps fall at cycles 8315, 16629, 24941 and 33255 and then repeat every 33254 cycles. Every step strobes quarter-frame. Only the 2nd and 4th steps also strobe half-frame.
- R4: In four-step mode with bit 6 = 0, the flag is driven set on the edges that end cycles 33254, 33255 and 33256. It is therefore first visible in cycle 33255 and cannot be cleared before cycle 33258.
- R5: A write with bit 7 = 1 shows both strobes in cycle 1. A write with bit 7 = 0 shows neither strobe in cycle 1.
- R6: In five-step mode the step after the write falls at cycle 1, and the next ones at 8315, 16629, 24941 and 33255. The sequence then wraps to cycle 41567. Steps 1 to 4 strobe quarter-frame, steps 1 and 3 strobe half-frame, and step 5 strobes nothing. Five-step mode never sets the flag.
- R7: A status read outside the set window clears the flag in the next cycle. A read during the set window leaves it set.
- R8: A write with bit 6 = 1 clears the flag in the next cycle. A write with bit 6 = 0 leaves the flag unchanged.
- R9: While the stored bit 6 is 1, the four-step sequence keeps its strobes but never sets the flag.
- R10: `frame_irq` always equals `frame_flag`.
- R11: A write in the middle of a sequence restarts it, so the next step falls 8315 cycles after the new write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 8 | Control byte: bit 7 sequence select, bit 6 interrupt inhibit |
| stat_rd | input | 1 | Status read strobe; clears the flag |
| qtr_pulse | output | 1 | Quarter-frame strobe, one cycle wide |
| half_pulse | output | 1 | Half-frame strobe, one cycle wide |
| frame_flag | output | 1 | Frame interrupt flag |
| frame_irq | output | 1 | Interrupt request, equal to the flag |

## Verification
The frame-flag set logic and the status-read clear can act on the same edge, and the set must win for all three edges of the window. The bench provokes this with a read in cycle 33255, another in cycle 33256 and a third in cycle 33257. It judges the result by the flag staying high in cycles 33256 and 33257 and dropping only in cycle 33258. The same bench also crosses a five-step write with a pending flag, and a clearing write with an immediate strobe, to confirm that each function keeps its own effect.

// File: rtl/afs_pkg.sv
// Package: shared types and helpers for the audio frame sequencer.
// Assumes: step indices never exceed 4 (five-step sequence).
package afs_pkg;

    typedef enum logic {
        SEQ_FOUR = 1'b0,
        SEQ_FIVE = 1'b1
    } seq_mode_e;

    localparam int STEP_IDX_W = 3;
    typedef logic [STEP_IDX_W-1:0] step_idx_t;

    // Larger of two integers, used to size counters from parameters.
    function automatic int max_i(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/afs_step_timer.sv
// Module: step timer. A down counter measures the gap to the pending step,
// fires when it reaches zero, then reloads the gap for the following step.
// Assumes: restart has priority over firing; in five-step mode the restart
// itself stands for step 1, so the timer leaves pointing at step 2.
module afs_step_timer
    import afs_pkg::*;
#(
    parameter int M0_FIRST    = 8315,
    parameter int M0_GAP_A    = 8314,
    parameter int M0_GAP_B    = 8312,
    parameter int M0_GAP_C    = 8314,
    parameter int M0_GAP_D    = 8314,
    parameter int M1_GAP_A    = 8314,
    parameter int M1_GAP_B    = 8314,
    parameter int M1_GAP_C    = 8312,
    parameter int M1_GAP_D    = 8314,
    parameter int M1_GAP_E    = 8312,
    parameter int ALIGN_EXTRA = 0,
    parameter int CNT_W       = 14
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      restart_five,
    input  seq_mode_e mode,
    output logic      fire,
    output step_idx_t pend_idx
);

    localparam int GAP4 [4] = '{M0_GAP_A, M0_GAP_B, M0_GAP_C, M0_GAP_D};
    localparam int GAP5 [5] = '{M1_GAP_A, M1_GAP_B, M1_GAP_C, M1_GAP_D, M1_GAP_E};
    localparam logic [CNT_W-1:0] LOAD_FOUR = CNT_W'(M0_FIRST - 2 + ALIGN_EXTRA);
    localparam logic [CNT_W-1:0] LOAD_FIVE = CNT_W'(M1_GAP_A - 1 + ALIGN_EXTRA);
    localparam int MAX_GAP = max_i(max_i(max_i(M0_GAP_A, M0_GAP_B), max_i(M0_GAP_C, M0_GAP_D)),
                             max_i(max_i(M1_GAP_A, M1_GAP_B), max_i(M1_GAP_C,
                             max_i(M1_GAP_D, M1_GAP_E))));
    localparam int MAX_LOAD = max_i(M0_FIRST - 1 + ALIGN_EXTRA, MAX_GAP + ALIGN_EXTRA);

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] gap_len;
    step_idx_t        last_idx;
    step_idx_t        next_idx;

    // Gap that follows the pending step, chosen by the current sequence.
    always_comb begin
        gap_len = '0;
        if (mode == SEQ_FIVE) begin
            for (int i = 0; i < 5; i++) begin
                if (pend_idx == step_idx_t'(i)) gap_len = CNT_W'(GAP5[i]);
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (pend_idx == step_idx_t'(i)) gap_len = CNT_W'(GAP4[i]);
            end
        end
    end

    // Index of the final step and the wrap to the first one.
    always_comb begin
        last_idx = (mode == SEQ_FIVE) ? step_idx_t'(4) : step_idx_t'(3);
        next_idx = (pend_idx == last_idx) ? '0 : pend_idx + step_idx_t'(1);
    end

    // A step fires when the counter is spent and no write restarts it.
    always_comb begin
        fire = (remain_q == '0) && !restart;
    end

    // Counter and pending step: reload on restart or step, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_idx <= '0;
            remain_q <= LOAD_FOUR;
        end else if (restart) begin
            if (restart_five) begin
                pend_idx <= step_idx_t'(1);
                remain_q <= LOAD_FIVE;
            end else begin
                pend_idx <= '0;
                remain_q <= LOAD_FOUR;
            end
        end else if (remain_q == '0) begin
            pend_idx <= next_idx;
            remain_q <= gap_len - CNT_W'(1);
        end else begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    p_remain_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q <= CNT_W'(MAX_LOAD));

    p_pend_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_idx <= ((mode == SEQ_FIVE) ? step_idx_t'(4) : step_idx_t'(3)));

    p_fire_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/afs_pulse_decode.sv
// Module: strobe decoder. Turns step events into registered quarter-frame
// and half-frame strobes, using a per-sequence step mask.
// Assumes: a five-step restart counts as step 1 of that sequence.
module afs_pulse_decode
    import afs_pkg::*;
#(
    parameter int NUM_SEQ = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      restart_five,
    input  seq_mode_e mode,
    input  logic      fire,
    input  step_idx_t pend_idx,
    output logic      qtr_pulse,
    output logic      half_pulse
);

    localparam int MASK_W = 1 << STEP_IDX_W;

    logic [MASK_W-1:0] qtr_mask  [NUM_SEQ];
    logic [MASK_W-1:0] half_mask [NUM_SEQ];

    // Step masks per sequence: bit i enables the strobe on step index i.
    for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq_mask
        if (s == int'(SEQ_FIVE)) begin : g_five
            assign qtr_mask[s]  = MASK_W'(8'b0000_1111);
            assign half_mask[s] = MASK_W'(8'b0000_0101);
        end else begin : g_four
            assign qtr_mask[s]  = MASK_W'(8'b0000_1111);
            assign half_mask[s] = MASK_W'(8'b0000_1010);
        end
    end

    // Register the strobes for one cycle on each step or five-step restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qtr_pulse  <= 1'b0;
            half_pulse <= 1'b0;
        end else if (restart) begin
            qtr_pulse  <= restart_five;
            half_pulse <= restart_five;
        end else if (fire) begin
            qtr_pulse  <= qtr_mask[int'(mode)][pend_idx];
            half_pulse <= half_mask[int'(mode)][pend_idx];
        end else begin
            qtr_pulse  <= 1'b0;
            half_pulse <= 1'b0;
        end
    end

    p_half_with_qtr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        half_pulse |-> qtr_pulse);

    p_five_immediate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && restart_five) |=> (qtr_pulse && half_pulse));

    p_four_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !restart_five) |=> (!qtr_pulse && !half_pulse));

endmodule

// File: rtl/afs_irq_flag.sv
// Module: frame interrupt flag. It is driven set on the last-step edge of
// the four-step sequence and on the two edges after it. A status read
// clears it outside that window; a write with the inhibit bit clears it.
// Assumes: the write edge itself never sets the flag (sequence restarts).
module afs_irq_flag
    import afs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      wr_inhibit,
    input  logic      inhibit_q,
    input  seq_mode_e mode,
    input  logic      fire,
    input  step_idx_t pend_idx,
    input  logic      stat_rd,
    output logic      frame_flag
);

    logic       last_fire;
    logic [1:0] tail_q;
    logic       set_now;

    // Last step of the four-step sequence is firing on this edge.
    always_comb begin
        last_fire = fire && (mode == SEQ_FOUR) && (pend_idx == step_idx_t'(3));
        set_now   = !inhibit_q && (mode == SEQ_FOUR) && (last_fire || (tail_q != 2'b00));
    end

    // Two-edge tail that stretches the set drive past the last step.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tail_q <= 2'b00;
        end else begin
            tail_q <= {tail_q[0], last_fire};
        end
    end

    // Flag: write decides first, then set drive, then read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_flag <= 1'b0;
        end else if (restart) begin
            frame_flag <= wr_inhibit ? 1'b0 : frame_flag;
        end else if (set_now) begin
            frame_flag <= 1'b1;
        end else if (stat_rd) begin
            frame_flag <= 1'b0;
        end
    end

    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !restart && !fire && tail_q == 2'b00) |=> !frame_flag);

    p_inhibit_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && wr_inhibit) |=> !frame_flag);

    p_plain_write_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !wr_inhibit) |=> (frame_flag == $past(frame_flag)));

    p_inhibit_blocks_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit_q && !restart) |=> !$rose(frame_flag));

    p_set_window_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(frame_flag) && !restart) |=> frame_flag);

endmodule

// File: rtl/afs_frame_seq.sv
// Module: audio frame sequencer top. Holds the control fields, then feeds
// the step timer, the strobe decoder and the interrupt flag.
// Assumes: bit 7 of the control byte picks the sequence and bit 6 inhibits
// the interrupt; reset acts like a write of 0x00 that also clears the flag.
module afs_frame_seq
    import afs_pkg::*;
#(
    parameter int M0_FIRST    = 8315,
    parameter int M0_GAP_A    = 8314,
    parameter int M0_GAP_B    = 8312,
    parameter int M0_GAP_C    = 8314,
    parameter int M0_GAP_D    = 8314,
    parameter int M1_GAP_A    = 8314,
    parameter int M1_GAP_B    = 8314,
    parameter int M1_GAP_C    = 8312,
    parameter int M1_GAP_D    = 8314,
    parameter int M1_GAP_E    = 8312,
    parameter int ALIGN_EXTRA = 0,
    parameter int DATA_W      = 8,
    parameter int MODE_BIT    = 7,
    parameter int INH_BIT     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_data,
    input  logic              stat_rd,
    output logic              qtr_pulse,
    output logic              half_pulse,
    output logic              frame_flag,
    output logic              frame_irq
);

    localparam int CNT_MAX = max_i(M0_FIRST, max_i(M1_GAP_A, M0_GAP_A)) + 2;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_mode_e mode_q;
    logic      inhibit_q;
    logic      wr_five;
    logic      wr_inh;
    logic      fire;
    step_idx_t pend_idx;

    // Decode the two control fields of the written byte.
    always_comb begin
        wr_five = ctrl_data[MODE_BIT];
        wr_inh  = ctrl_data[INH_BIT];
    end

    // Control register: sequence select and interrupt inhibit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= SEQ_FOUR;
            inhibit_q <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q    <= wr_five ? SEQ_FIVE : SEQ_FOUR;
            inhibit_q <= wr_inh;
        end
    end

    afs_step_timer #(
        .M0_FIRST   (M0_FIRST),
        .M0_GAP_A   (M0_GAP_A),
        .M0_GAP_B   (M0_GAP_B),
        .M0_GAP_C   (M0_GAP_C),
        .M0_GAP_D   (M0_GAP_D),
        .M1_GAP_A   (M1_GAP_A),
        .M1_GAP_B   (M1_GAP_B),
        .M1_GAP_C   (M1_GAP_C),
        .M1_GAP_D   (M1_GAP_D),
        .M1_GAP_E   (M1_GAP_E),
        .ALIGN_EXTRA(ALIGN_EXTRA),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (ctrl_wr),
        .restart_five(wr_five),
        .mode        (mode_q),
        .fire        (fire),
        .pend_idx    (pend_idx)
    );

    afs_pulse_decode #(
        .NUM_SEQ(2)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (ctrl_wr),
        .restart_five(wr_five),
        .mode        (mode_q),
        .fire        (fire),
        .pend_idx    (pend_idx),
        .qtr_pulse   (qtr_pulse),
        .half_pulse  (half_pulse)
    );

    afs_irq_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (ctrl_wr),
        .wr_inhibit(wr_inh),
        .inhibit_q (inhibit_q),
        .mode      (mode_q),
        .fire      (fire),
        .pend_idx  (pend_idx),
        .stat_rd   (stat_rd),
        .frame_flag(frame_flag)
    );

    // Interrupt request follows the flag.
    assign frame_irq = frame_flag;

    p_irq_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq == frame_flag);

    p_five_never_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SEQ_FIVE && !ctrl_wr) |=> !$rose(frame_flag));

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!qtr_pulse && !half_pulse && !frame_flag));

endmodule

// File: tb/afs_frame_seq_test.sv
// Bench: a vector table walked by one loop, then directed tests for the
// reset, read-during-set, clearing-write and restart corner cases.
module afs_frame_seq_test;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 195000;

    typedef struct packed {
        logic [7:0]  wd;    // byte to write when off == 0
        logic [17:0] off;   // cycle after the last write to sample
        logic        q;
        logic        h;
        logic        f;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 18'd0,     1'b0, 1'b0, 1'b0, 4'd0},  // write four-step
        '{8'h00, 18'd1,     1'b0, 1'b0, 1'b0, 4'd5},  // R5 no immediate
        '{8'h00, 18'd8314,  1'b0, 1'b0, 1'b0, 4'd2},  // R2 early edge
        '{8'h00, 18'd8315,  1'b1, 1'b0, 1'b0, 4'd2},  // R2 step 1
        '{8'h00, 18'd8316,  1'b0, 1'b0, 1'b0, 4'd2},  // R2 one cycle
        '{8'h00, 18'd16629, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 step 2
        '{8'h00, 18'd24941, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 step 3
        '{8'h00, 18'd33254, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 not yet
        '{8'h00, 18'd33255, 1'b1, 1'b1, 1'b1, 4'd4},  // R4 step 4 + flag
        '{8'h00, 18'd33256, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 flag holds
        '{8'h80, 18'd0,     1'b0, 1'b0, 1'b0, 4'd0},  // write five-step
        '{8'h80, 18'd1,     1'b1, 1'b1, 1'b1, 4'd5},  // R5 immediate, R8 kept
        '{8'h80, 18'd2,     1'b0, 1'b0, 1'b1, 4'd6},  // R6
        '{8'h80, 18'd8315,  1'b1, 1'b0, 1'b1, 4'd6},  // R6 step 2
        '{8'h80, 18'd16629, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 step 3
        '{8'h80, 18'd24941, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 step 4
        '{8'h80, 18'd33255, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 step 5 silent
        '{8'h80, 18'd41567, 1'b1, 1'b1, 1'b1, 4'd6},  // R6 wrap
        '{8'hC0, 18'd0,     1'b0, 1'b0, 1'b0, 4'd0},  // write five + inhibit
        '{8'hC0, 18'd1,     1'b1, 1'b1, 1'b0, 4'd8},  // R8 cleared, R5 strobes
        '{8'h40, 18'd0,     1'b0, 1'b0, 1'b0, 4'd0},  // write four + inhibit
        '{8'h40, 18'd33255, 1'b1, 1'b1, 1'b0, 4'd9}   // R9 strobes, no flag
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_data = 8'h00;
    logic       stat_rd = 1'b0;
    logic       qtr_pulse;
    logic       half_pulse;
    logic       frame_flag;
    logic       frame_irq;

    int checks = 0;
    int fails  = 0;
    int cur    = 0;

    afs_frame_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_data (ctrl_data),
        .stat_rd   (stat_rd),
        .qtr_pulse (qtr_pulse),
        .half_pulse(half_pulse),
        .frame_flag(frame_flag),
        .frame_irq (frame_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b", tag, what, cur, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] d);
        ctrl_wr   = 1'b1;
        ctrl_data = d;
        @(negedge clk);
        ctrl_wr   = 1'b0;
        cur       = 1;
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        cur++;
    endtask

    task automatic goto(input int n);
        repeat (n - cur) @(negedge clk);
        cur = n;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "qtr in reset", qtr_pulse, 1'b0);
        check("R1", "flag in reset", frame_flag, 1'b0);
        rst_n = 1'b1;
        cur   = 1;
        check("R1", "half after reset", half_pulse, 1'b0);
        goto(8314);
        check("R1", "no step before 8315", qtr_pulse, 1'b0);
        goto(8315);
        check("R1", "first step after reset", qtr_pulse, 1'b1);

        // Table walk: R2 R3 R4 R5 R6 R8 R9
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].off == 18'd0) begin
                do_write(VECS[i].wd);
            end else begin
                goto(int'(VECS[i].off));
                check($sformatf("R%0d", VECS[i].req), $sformatf("qtr vec %0d", i), qtr_pulse, VECS[i].q);
                check($sformatf("R%0d", VECS[i].req), $sformatf("half vec %0d", i), half_pulse, VECS[i].h);
                check($sformatf("R%0d", VECS[i].req), $sformatf("flag vec %0d", i), frame_flag, VECS[i].f);
            end
        end

        // R7 and R4: reads inside the set window do not clear; R10 mirror
        do_write(8'h00);
        goto(33255);
        check("R10", "irq equals flag", frame_irq, 1'b1);
        do_read();
        check("R7", "read in window kept", frame_flag, 1'b1);
        do_read();
        check("R4", "read at window end kept", frame_flag, 1'b1);
        do_read();
        check("R7", "read after window clears", frame_flag, 1'b0);
        check("R10", "irq follows clear", frame_irq, 1'b0);

        // R11: restart in mid sequence
        do_write(8'h00);
        goto(5000);
        do_write(8'h00);
        goto(8314);
        check("R11", "no step before restart time", qtr_pulse, 1'b0);
        goto(8315);
        check("R11", "step after restart", qtr_pulse, 1'b1);

        // R1: reset mid-run clears the strobes
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "qtr cleared by reset", qtr_pulse, 1'b0);
        check("R1", "flag cleared by reset", frame_flag, 1'b0);
        rst_n = 1'b1;

        summary();
    end

endmodule